// File: doc/BRIEF.md
# Multi-format stereo audio serial transmitter

This block takes a left and a right audio sample as parallel words and sends them one bit at a time on a single serial data line. Two framing clocks go with the data. A bit clock sets the pace, and every output change happens on its falling edge. An alignment clock tells the receiver which channel is on the line. Each frame has 64 bit slots, 32 for each channel.

A run-time mode input decides who owns the clocks. In master mode the block divides its system clock to make the bit clock and produces the alignment clock itself. In slave mode it synchronizes clocks that arrive from outside, detects their edges and answers with data.

Two configuration codes select the framing and the word length:
- Framing is right-justified, left-justified or I2S.
- Word length is 16, 20 or 24 bits.

Both codes, and the new sample pair, are taken in together at the start of each frame. The upstream filter sees a one-cycle pulse each time this happens.

Top module: `audio_ser_tx`

## Requirements
- R1: In master mode (`ms`=1) the generated bit clock has a period of `CLK_DIV` system clocks, `clk_oe` is 1, and each half-frame spans exactly 32 bit clocks, so a frame is 64 bit clocks.
- R2: In master mode `dout` and `lrclk_o` change only in the system cycle where `bclk_o` falls.
- R3: Framing code 01 (left-justified): the alignment clock is high for the left channel and the MSB is in slot 0, the first slot after the alignment edge.
- R4: Framing codes 10 and 11 (I2S): the alignment clock is low for the left channel and the MSB is in slot 1, one bit clock after the alignment edge.
- R5: Framing code 00 (right-justified): the alignment clock is high for the left channel, the first bit is in slot 32-W and the LSB is in slot 31.
- R6: Word length code 00 gives W=16, 01 gives W=20, and 10 or 11 gives W=24. The W bits sent are the W most significant bits of the 24-bit input word, MSB first. Every slot that holds no data bit is driven low.
- R7: `take` is a single-cycle pulse at each frame start, where the frame start is the first slot of the left half. The pair on `left_in`/`right_in` is captured in that cycle. Frame starts are 64 bit clocks apart.
- R8: A change of `fmt_sel` or `wl_sel` during a frame does not affect that frame. It takes effect from the next frame start.
- R9: In slave mode (`ms`=0) `clk_oe` is 0 and `bclk_o` stays low. The block follows `bclk_i`/`lrclk_i`: a frame starts on an alignment change to the left level of the selected framing, the slot count restarts at every alignment change, and each data bit is presented after a falling edge of `bclk_i`.
- R10: During reset `bclk_o`, `lrclk_o`, `dout` and `take` are 0 and `clk_oe` equals `ms`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms | input | 1 | Clock role: 1 master, 0 slave |
| fmt_sel | input | 2 | Framing: 00 right-justified, 01 left-justified, 1x I2S |
| wl_sel | input | 2 | Word length: 00 16 bits, 01 20 bits, 1x 24 bits |
| left_in | input | SAMPLE_W | Left sample, MSB-aligned |
| right_in | input | SAMPLE_W | Right sample, MSB-aligned |
| take | output | 1 | Pulse: sample pair and configuration captured |
| bclk_i | input | 1 | Bit clock from outside (slave mode) |
| lrclk_i | input | 1 | Alignment clock from outside (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode) |
| lrclk_o | output | 1 | Generated alignment clock |
| clk_oe | output | 1 | Drive enable for the clock pins |
| dout | output | 1 | Serial audio data |

## Verification
The bench acts as a receiver. It decodes every half-frame on the rising bit clock and compares it with a pattern worked out from the word length and framing in force. It sweeps all nine framing and word-length pairs in master mode plus the alias codes 11, so a wrong start offset shows up as a whole half-frame shifted by a slot. A stale tail of bits shows up as nonzero bits in the padding slots. A swapped I2S polarity shows up as channels crossed. One run changes the configuration in the middle of a frame: a design that applies it at once sends that frame with the new length and alignment. The slave runs, in all three framings, catch a design that keeps counting slots across an external alignment edge or that sends a frame before the left edge arrives.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

   typedef struct packed {
      logic [1:0] fmt;
      logic [1:0] wl;
   } ser_cfg_t;

   // alignment clock level that marks the left channel
   function automatic logic left_level(input logic [1:0] fmt);
      return fmt[1] ? 1'b0 : 1'b1;
   endfunction

   function automatic int unsigned word_bits(input logic [1:0] wl);
      case (wl)
         2'b00:   return 16;
         2'b01:   return 20;
         default: return 24;
      endcase
   endfunction

endpackage

// File: rtl/audio_ser_mclk.sv
module audio_ser_mclk #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic bclk,
   output logic fall
);
   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);

   logic [CW-1:0] cnt_q;
   logic          bclk_q;
   logic          tick;

   assign tick = en && (cnt_q == CNT_LAST);
   assign fall = tick && bclk_q;
   assign bclk = bclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q  <= '0;
         bclk_q <= 1'b0;
      end else if (tick) begin
         cnt_q  <= '0;
         bclk_q <= ~bclk_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/audio_ser_sclk.sv
module audio_ser_sclk #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bclk_ext,
   input  logic lrclk_ext,
   output logic fall,
   output logic lr_level
);
   localparam int LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] b_sync;
   logic [SYNC_STAGES-1:0] l_sync;
   logic                   b_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         b_sync   <= '0;
         l_sync   <= '0;
         b_prev_q <= 1'b0;
      end else begin
         b_sync[0] <= bclk_ext;
         l_sync[0] <= lrclk_ext;
         for (int i = 1; i < SYNC_STAGES; i++) begin
            b_sync[i] <= b_sync[i-1];
            l_sync[i] <= l_sync[i-1];
         end
         b_prev_q <= b_sync[LAST];
      end
   end

   assign fall     = en && b_prev_q && !b_sync[LAST];
   assign lr_level = l_sync[LAST];
endmodule

// File: rtl/audio_ser_frame.sv
module audio_ser_frame
   import audio_ser_pkg::*;
#(
   parameter int SAMPLE_W   = 24,
   parameter int HALF_SLOTS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                master,
   input  logic                fall,
   input  logic                lr_in,
   input  logic [1:0]          fmt_sel,
   input  logic [1:0]          wl_sel,
   input  logic [SAMPLE_W-1:0] left_in,
   input  logic [SAMPLE_W-1:0] right_in,
   output logic                take,
   output logic                lrclk,
   output logic                dout
);
   localparam int POS_W = $clog2(HALF_SLOTS);
   localparam int LW    = POS_W + 1;
   localparam logic [POS_W-1:0] POS_LAST = POS_W'(HALF_SLOTS - 1);

   logic [POS_W-1:0]    pos_q, npos;
   logic                ch_q, nch, nstart, lr_prev_q, lr_chg;
   ser_cfg_t            cfg_q, ncfg;
   logic [SAMPLE_W-1:0] left_q, right_q, nleft, nright, nsample, shifted;
   logic [LW-1:0]       wbits_v, lead_v, pos_ext, jj;
   logic                nbit, nlr, in_word;
   logic                lrclk_q, dout_q, take_q;

   always_comb begin
      lr_chg = lr_in != lr_prev_q;
      if (master) begin
         npos   = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
         nch    = (pos_q == POS_LAST) ? ~ch_q : ch_q;
         nstart = (pos_q == POS_LAST) && ch_q;
      end else begin
         npos   = lr_chg ? '0 : ((pos_q == POS_LAST) ? pos_q : pos_q + 1'b1);
         nstart = lr_chg && (lr_in == left_level(fmt_sel));
         nch    = lr_chg ? ~nstart : ch_q;
      end
      ncfg    = nstart ? '{fmt: fmt_sel, wl: wl_sel} : cfg_q;
      nleft   = nstart ? left_in  : left_q;
      nright  = nstart ? right_in : right_q;
      nsample = nch ? nright : nleft;
      wbits_v = LW'(word_bits(ncfg.wl));
      case (ncfg.fmt)
         2'b00:   lead_v = LW'(HALF_SLOTS) - wbits_v;
         2'b01:   lead_v = '0;
         default: lead_v = LW'(1);
      endcase
      pos_ext = {1'b0, npos};
      jj      = pos_ext - lead_v;
      in_word = (pos_ext >= lead_v) && (jj < wbits_v);
      shifted = nsample << jj;
      nbit    = in_word && shifted[SAMPLE_W-1];
      nlr     = nch ? ~left_level(ncfg.fmt) : left_level(ncfg.fmt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q     <= POS_LAST;
         ch_q      <= 1'b1;
         lr_prev_q <= 1'b0;
         cfg_q     <= '0;
         left_q    <= '0;
         right_q   <= '0;
         lrclk_q   <= 1'b0;
         dout_q    <= 1'b0;
         take_q    <= 1'b0;
      end else begin
         take_q <= fall && nstart;
         if (fall) begin
            pos_q     <= npos;
            ch_q      <= nch;
            lr_prev_q <= lr_in;
            cfg_q     <= ncfg;
            left_q    <= nleft;
            right_q   <= nright;
            lrclk_q   <= nlr;
            dout_q    <= nbit;
         end
      end
   end

   assign take  = take_q;
   assign lrclk = lrclk_q;
   assign dout  = dout_q;
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
   parameter int SAMPLE_W    = 24,
   parameter int HALF_SLOTS  = 32,
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ms,
   input  logic [1:0]          fmt_sel,
   input  logic [1:0]          wl_sel,
   input  logic [SAMPLE_W-1:0] left_in,
   input  logic [SAMPLE_W-1:0] right_in,
   output logic                take,
   input  logic                bclk_i,
   input  logic                lrclk_i,
   output logic                bclk_o,
   output logic                lrclk_o,
   output logic                clk_oe,
   output logic                dout
);
   generate
      if (SAMPLE_W < 24) begin : g_bad_width
         $error("SAMPLE_W must hold a 24-bit word");
      end
      if (HALF_SLOTS < SAMPLE_W + 1 || (HALF_SLOTS & (HALF_SLOTS - 1)) != 0) begin : g_bad_slots
         $error("HALF_SLOTS must be a power of two above SAMPLE_W");
      end
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic m_fall, s_fall, s_lr, fall;

   audio_ser_mclk #(.CLK_DIV(CLK_DIV)) u_mclk (
      .clk(clk), .rst_n(rst_n), .en(ms), .bclk(bclk_o), .fall(m_fall)
   );

   audio_ser_sclk #(.SYNC_STAGES(SYNC_STAGES)) u_sclk (
      .clk(clk), .rst_n(rst_n), .en(!ms), .bclk_ext(bclk_i),
      .lrclk_ext(lrclk_i), .fall(s_fall), .lr_level(s_lr)
   );

   assign fall   = ms ? m_fall : s_fall;
   assign clk_oe = ms;

   audio_ser_frame #(.SAMPLE_W(SAMPLE_W), .HALF_SLOTS(HALF_SLOTS)) u_frame (
      .clk(clk), .rst_n(rst_n), .master(ms), .fall(fall), .lr_in(s_lr),
      .fmt_sel(fmt_sel), .wl_sel(wl_sel), .left_in(left_in),
      .right_in(right_in), .take(take), .lrclk(lrclk_o), .dout(dout)
   );
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ms,
   input logic [1:0] fmt_sel,
   input logic       take,
   input logic       bclk_o,
   input logic       lrclk_o,
   input logic       dout
);
   // R2
   dout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ms && $past(ms) && !$stable(dout)) |-> $fell(bclk_o));

   // R2
   lrclk_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ms && $past(ms) && !$stable(lrclk_o)) |-> $fell(bclk_o));

   // R7
   take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !take);

   // R3 R4
   left_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (lrclk_o == !$past(fmt_sel[1])));

   // R9
   slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ms |-> !bclk_o);
endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (.*);

// File: tb/audio_ser_tx_bench.sv
module audio_ser_tx_bench;
   localparam int CLK_DIV = 4;
   localparam int S_HALF  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ms = 1'b1;
   logic [1:0]  fmt_sel = 2'b01;
   logic [1:0]  wl_sel = 2'b00;
   logic [23:0] left_in = '0;
   logic [23:0] right_in = '0;
   logic        take, bclk_o, lrclk_o, clk_oe, dout;
   logic        sb_bclk = 1'b1;
   logic        sb_lr = 1'b0;

   always #10 clk = ~clk;

   audio_ser_tx #(.CLK_DIV(CLK_DIV)) u_audio_ser_tx (
      .clk(clk), .rst_n(rst_n), .ms(ms), .fmt_sel(fmt_sel), .wl_sel(wl_sel),
      .left_in(left_in), .right_in(right_in), .take(take),
      .bclk_i(sb_bclk), .lrclk_i(sb_lr), .bclk_o(bclk_o), .lrclk_o(lrclk_o),
      .clk_oe(clk_oe), .dout(dout)
   );

   int n_chk = 0, n_fail = 0;
   int edge_err, per_err, take_err, slave_err, n_take, n_half;
   string phase_tag = "";

   function automatic logic lvl(input logic [1:0] f);
      return f[1] ? 1'b0 : 1'b1;
   endfunction

   function automatic logic [23:0] sample_of(input int n, input bit ch);
      return 24'hA5C3F1 ^ (24'(n) * 24'h13579B) ^ (ch ? 24'h5A69E2 : 24'h0);
   endfunction

   function automatic logic [31:0] exp_half(input logic [1:0] f, input logic [1:0] w,
                                            input logic [23:0] s);
      logic [31:0] e = '0;
      int wb = (w == 2'b00) ? 16 : (w == 2'b01) ? 20 : 24;
      int o  = (f == 2'b01) ? 0 : f[1] ? 1 : 32 - wb;
      for (int p = 0; p < 32; p++) begin
         int j = p - o;
         if (j >= 0 && j < wb) e[31-p] = s[23-j];
      end
      return e;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // receiver and stimulus follower, sampled on the falling system edge
   logic        prev_b, prev_dout, prev_lro, rx_lr, rx_valid, rx_snap_ok, have_lat, rx_ch;
   logic        bus_b, bus_l;
   logic [31:0] rx_bits;
   int          rx_n, cyc, last_rise, last_take, frame_n;
   logic [23:0] lat_l, lat_r, snap_l, snap_r;
   logic [1:0]  lat_fmt, lat_wl, snap_fmt, snap_wl;

   task automatic eval_half();
      logic [31:0] e = exp_half(snap_fmt, snap_wl, rx_ch ? snap_r : snap_l);
      string ft = (snap_fmt == 2'b00) ? "R5" : (snap_fmt == 2'b01) ? "R3" : "R4";
      n_half++;
      check(rx_n == 32, $sformatf("%s R1", ft), "half-frame slot count",
            32'(rx_n), 32);
      check(rx_bits == e, $sformatf("%s R6%s", ft, phase_tag),
            $sformatf("half ch=%0d fmt=%0d wl=%0d", rx_ch, snap_fmt, snap_wl), rx_bits, e);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         bus_b = ms ? bclk_o : sb_bclk;
         bus_l = ms ? lrclk_o : sb_lr;
         if (!rst_n) begin
            rx_lr = bus_l; rx_valid = 0; rx_snap_ok = 0; have_lat = 0;
            rx_n = 0; rx_bits = '0; last_rise = 0; last_take = 0; cyc = 0;
         end else begin
            cyc++;
            if (take) begin
               if (last_take != 0 && cyc - last_take != 64 * (ms ? CLK_DIV : 2 * S_HALF))
                  take_err++;
               last_take = cyc;
               lat_l = left_in; lat_r = right_in; lat_fmt = fmt_sel; lat_wl = wl_sel;
               have_lat = 1; n_take++;
               frame_n++;
               left_in  = sample_of(frame_n, 0);
               right_in = sample_of(frame_n, 1);
            end
            if (ms && (dout != prev_dout || lrclk_o != prev_lro) && !(prev_b && !bus_b))
               edge_err++;
            if (!ms && bclk_o) slave_err++;
            if (bus_b && !prev_b) begin
               if (ms) begin
                  if (last_rise != 0 && cyc - last_rise != CLK_DIV) per_err++;
                  last_rise = cyc;
               end
               if (bus_l != rx_lr) begin
                  if (rx_valid) eval_half();
                  rx_ch = (bus_l == lvl(lat_fmt)) ? 1'b0 : 1'b1;
                  if (!rx_ch) begin
                     snap_l = lat_l; snap_r = lat_r; snap_fmt = lat_fmt; snap_wl = lat_wl;
                     rx_snap_ok = have_lat;
                  end
                  rx_valid = rx_snap_ok;
                  rx_n = 0; rx_bits = '0;
               end
               if (rx_n < 32) rx_bits[31-rx_n] = dout;
               if (rx_n < 40) rx_n++;
               rx_lr = bus_l;
            end
         end
         prev_b = bus_b; prev_dout = dout; prev_lro = lrclk_o;
      end
   end

   task automatic do_reset(input logic m, input logic [1:0] f, input logic [1:0] w);
      @(posedge clk);
      rst_n <= 1'b0; ms <= m; fmt_sel <= f; wl_sel <= w;
      sb_bclk <= 1'b1; sb_lr <= ~lvl(f);
      edge_err = 0; per_err = 0; take_err = 0; slave_err = 0; n_take = 0; n_half = 0;
      frame_n = 0;
      left_in = sample_of(0, 0); right_in = sample_of(0, 1);
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R10
      check({bclk_o, lrclk_o, dout, take} == 4'b0, "R10", "outputs in reset",
            {28'b0, bclk_o, lrclk_o, dout, take}, 0);
      check(clk_oe == m, m ? "R10 R1" : "R10 R9", "clk_oe", 32'(clk_oe), 32'(m));
      rst_n = 1'b1;
   endtask

   task automatic post_run(input int frames);
      if (ms) begin
         check(edge_err == 0, "R2", "changes away from bclk fall", 32'(edge_err), 0);
         check(per_err == 0, "R1", "bclk period errors", 32'(per_err), 0);
      end else begin
         check(slave_err == 0, "R9", "bclk_o active in slave", 32'(slave_err), 0);
      end
      check(take_err == 0, "R7", "frame start spacing errors", 32'(take_err), 0);
      check(n_take >= frames - 1, "R7", "frame starts seen", 32'(n_take), 32'(frames - 1));
      check(n_half >= 2 * frames - 3, "R1", "half-frames decoded", 32'(n_half),
            32'(2 * frames - 3));
   endtask

   task automatic master_run(input logic [1:0] f, input logic [1:0] w, input int frames);
      do_reset(1'b1, f, w);
      repeat (frames * 64 * CLK_DIV) @(posedge clk);
      post_run(frames);
   endtask

   task automatic slave_run(input logic [1:0] f, input logic [1:0] w, input int frames);
      logic lv = lvl(f);
      do_reset(1'b0, f, w);
      phase_tag = " R9";
      repeat (3) @(posedge clk);
      for (int fr = 0; fr < frames; fr++) begin
         for (int s = 0; s < 64; s++) begin
            @(posedge clk);
            sb_bclk <= 1'b0;
            sb_lr   <= (s < 32) ? lv : ~lv;
            repeat (S_HALF) @(posedge clk);
            sb_bclk <= 1'b1;
            repeat (S_HALF - 1) @(posedge clk);
         end
      end
      repeat (4) @(posedge clk);
      post_run(frames);
      phase_tag = "";
   endtask

   initial begin
      for (int f = 0; f < 3; f++)
         for (int w = 0; w < 3; w++)
            master_run(2'(f), 2'(w), 6);
      master_run(2'b11, 2'b11, 5);

      // R8: reconfigure in the middle of a frame
      do_reset(1'b1, 2'b01, 2'b00);
      repeat (2 * 64 * CLK_DIV) @(posedge clk);
      @(negedge clk);
      while (!take) @(negedge clk);
      repeat (20) @(negedge clk);
      phase_tag = " R8";
      fmt_sel = 2'b00; wl_sel = 2'b10;
      repeat (3 * 64 * CLK_DIV) @(posedge clk);
      post_run(5);
      phase_tag = "";

      slave_run(2'b01, 2'b10, 4);
      slave_run(2'b10, 2'b10, 4);
      slave_run(2'b00, 2'b10, 4);
      slave_run(2'b00, 2'b00, 3);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule